// File: doc/BRIEF.md
# Halt Handshake Compliance Monitor

This block watches the halt exchange between a hashing engine and a cipher engine that share one power budget. The hash side raises a halt request. The cipher side answers with an acknowledge once its engine is quiet. The monitor samples both handshake lines, the hash-round start strobe, the cipher busy level and a strobe that marks each output produced in approved mode. It reports every rule that is broken through a set of sticky error flags.

The monitor also keeps a ledger of handshakes that have finished but have not yet been claimed. Each approved output must claim one of them. Hash rounds can start without an active halt. The monitor counts these rounds and checks that two of them never come closer together than a minimum spacing, which is 100 cycles by default. In normal operation such rounds are about 1000 cycles apart.

The block only observes. It never drives the engines it watches.

Top module: `halt_monitor`

## Requirements
- R1: After reset, all bits of `err_o` are 0 and `unhalted_cnt_o` is 0.
- R2: A handshake is complete when the acknowledge falls while the request is low. Each completion adds one credit. An approved-output strobe with one or more credits removes one credit and leaves `err_o[0]` at 0.
- R3: An approved-output strobe when there are no credits (and no completion in the same cycle) sets `err_o[0]` (underflow).
- R4: The credit count saturates at `CREDIT_MAX` (default 8). Completions beyond that are lost, so after `CREDIT_MAX`+2 completions, exactly `CREDIT_MAX` strobes pass and the next one sets `err_o[0]`.
- R5: A hash-round strobe in a cycle where the request and the acknowledge are not both high sets `err_o[1]`. A strobe while both are high does not set it.
- R6: Cipher busy while the request and the acknowledge are both high sets `err_o[2]`. Cipher busy outside a halt does not set it.
- R7: The acknowledge falling while the request is high sets `err_o[3]`.
- R8: The acknowledge rising while the request is low sets `err_o[4]`.
- R9: Two unhalted hash rounds whose start cycles differ by fewer than `MIN_GAP` cycles set `err_o[5]`. A difference of exactly `MIN_GAP` does not set it, and the first unhalted round after reset never sets it.
- R10: `unhalted_cnt_o` goes up by one for each unhalted hash round and saturates at all ones (16 bits by default).
- R11: Each flag is set in the cycle after its violation and stays set until `clear_i` is pulsed. A clear zeroes the flags in the next cycle, except for violations seen in the same cycle as the clear, which are kept. A clear does not change the credits or `unhalted_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Pulse that clears the sticky error flags |
| halt_req_i | input | 1 | Halt request from the hash side |
| halt_ack_i | input | 1 | Halt acknowledge from the cipher side |
| hash_run_i | input | 1 | One-cycle strobe marking the start of a hash round |
| cipher_busy_i | input | 1 | High while the cipher engine is computing |
| approved_out_i | input | 1 | One-cycle strobe for each approved-mode output |
| err_o | output | 6 | Sticky flags: [0] underflow, [1] unhalted hash, [2] cipher during halt, [3] acknowledge fell early, [4] acknowledge rose unasked, [5] spacing |
| unhalted_cnt_o | output | 16 | Saturating count of hash rounds started without a halt |

## Verification
The credit ledger is tested three ways. A balanced pattern of one handshake then one output must show no error. An unbalanced pattern with an output and no handshake must flag the underflow. An oversupply of handshakes must show exactly where saturation cuts the credits off. Hash strobes are given both inside and outside a halt, which separates the mutual-exclusion check from the counter. Pairs of unhalted strobes one cycle under and exactly at the minimum gap locate the spacing boundary. Each malformed handshake is given alone, so each flag is shown to be set only by its own rule.

// File: rtl/hmon_pkg.sv
package hmon_pkg;
  localparam int ERR_W       = 6;
  localparam int E_UNDERFLOW = 0;
  localparam int E_MUTEX     = 1;
  localparam int E_CIPHER    = 2;
  localparam int E_ACK_FALL  = 3;
  localparam int E_ACK_RISE  = 4;
  localparam int E_SPACING   = 5;
endpackage

// File: rtl/hmon_handshake.sv
// Tracks acknowledge edges and flags out-of-order transitions.
module hmon_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  output logic done_o,
  output logic fall_err_o,
  output logic rise_err_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  // the exchange closes when the acknowledge falls after the request dropped
  assign done_o     = ack_q & ~ack_i & ~req_i;
  assign fall_err_o = ack_q & ~ack_i & req_i;
  assign rise_err_o = ~ack_q & ack_i & ~req_i;
endmodule

// File: rtl/hmon_credit.sv
// Saturating ledger of finished-but-unclaimed handshakes.
module hmon_credit #(
  parameter int CREDIT_MAX = 8,
  localparam int CW = $clog2(CREDIT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic          take_i,
  output logic [CW-1:0] credit_o,
  output logic          underflow_o
);
  logic [CW-1:0] credit_q, credit_d;

  always_comb begin
    credit_d    = credit_q;
    underflow_o = 1'b0;
    if (add_i && !take_i) begin
      if (credit_q != CW'(CREDIT_MAX)) credit_d = credit_q + CW'(1);
    end else if (take_i && !add_i) begin
      if (credit_q == '0) underflow_o = 1'b1;
      else                credit_d    = credit_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= credit_d;
  end

  assign credit_o = credit_q;
endmodule

// File: rtl/hmon_gap.sv
// Counts unhalted hash rounds and checks their minimum spacing.
module hmon_gap #(
  parameter int MIN_GAP = 100,
  parameter int CNT_W   = 16,
  localparam int GW = $clog2(MIN_GAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic             spacing_err_o,
  output logic [CNT_W-1:0] count_o
);
  logic [GW-1:0]    gap_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  // gap_q holds the cycles since the last unhalted round, capped at MIN_GAP
  assign spacing_err_o = strobe_i & seen_q & (gap_q < GW'(MIN_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (strobe_i) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
        if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
      end else if (gap_q < GW'(MIN_GAP)) begin
        gap_q <= gap_q + GW'(1);
      end
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/halt_monitor.sv
module halt_monitor #(
  parameter int CREDIT_MAX = 8,
  parameter int MIN_GAP    = 100,
  parameter int CNT_W      = 16,
  localparam int CREDIT_W  = $clog2(CREDIT_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     halt_req_i,
  input  logic                     halt_ack_i,
  input  logic                     hash_run_i,
  input  logic                     cipher_busy_i,
  input  logic                     approved_out_i,
  output logic [hmon_pkg::ERR_W-1:0] err_o,
  output logic [CNT_W-1:0]         unhalted_cnt_o
);
  import hmon_pkg::*;

  logic                halted;
  logic                hs_done, fall_err, rise_err;
  logic                underflow, spacing_err, unhalted;
  logic [CREDIT_W-1:0] credit_q;
  logic [ERR_W-1:0]    hit, flags_q;

  assign halted   = halt_req_i & halt_ack_i;
  assign unhalted = hash_run_i & ~halted;

  hmon_handshake u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (halt_req_i),
    .ack_i      (halt_ack_i),
    .done_o     (hs_done),
    .fall_err_o (fall_err),
    .rise_err_o (rise_err)
  );

  hmon_credit #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .add_i       (hs_done),
    .take_i      (approved_out_i),
    .credit_o    (credit_q),
    .underflow_o (underflow)
  );

  hmon_gap #(.MIN_GAP(MIN_GAP), .CNT_W(CNT_W)) u_gap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_i      (unhalted),
    .spacing_err_o (spacing_err),
    .count_o       (unhalted_cnt_o)
  );

  always_comb begin
    hit              = '0;
    hit[E_UNDERFLOW] = underflow;
    hit[E_MUTEX]     = unhalted;
    hit[E_CIPHER]    = cipher_busy_i & halted;
    hit[E_ACK_FALL]  = fall_err;
    hit[E_ACK_RISE]  = rise_err;
    hit[E_SPACING]   = spacing_err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (clear_i) flags_q <= hit;
    else              flags_q <= flags_q | hit;
  end

  assign err_o = flags_q;
endmodule

// File: rtl/hmon_checker.sv
module hmon_checker #(
  parameter int CREDIT_MAX = 8,
  parameter int CW         = 4,
  parameter int CNT_W      = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             req_i,
  input logic             ack_i,
  input logic             hash_i,
  input logic             cipher_i,
  input logic             approved_i,
  input logic             done_i,
  input logic [CW-1:0]    credit_i,
  input logic [5:0]       err_i,
  input logic [CNT_W-1:0] cnt_i
);
  p_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    approved_i && credit_i == '0 && !done_i |=> err_i[0]);

  p_credit_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_i <= CW'(CREDIT_MAX));

  p_mutex_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_i && !(req_i && ack_i) |=> err_i[1]);

  p_cipher_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cipher_i && req_i && ack_i |=> err_i[2]);

  p_ack_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_i) && req_i |=> err_i[3]);

  p_ack_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) && !req_i |=> err_i[4]);

  p_count_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_i && !(req_i && ack_i) && cnt_i != {CNT_W{1'b1}} |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (err_i & $past(err_i)) == $past(err_i));
endmodule

bind halt_monitor hmon_checker #(
  .CREDIT_MAX(CREDIT_MAX), .CW(CREDIT_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .req_i      (halt_req_i),
  .ack_i      (halt_ack_i),
  .hash_i     (hash_run_i),
  .cipher_i   (cipher_busy_i),
  .approved_i (approved_out_i),
  .done_i     (hs_done),
  .credit_i   (credit_q),
  .err_i      (err_o),
  .cnt_i      (unhalted_cnt_o)
);

// File: tb/tb_halt_monitor.sv
`timescale 1ns/1ps
module tb_halt_monitor;
  localparam int CMAX = 8;
  localparam int GAP  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 0, req = 0, ack = 0, hash = 0, cipher = 0, appr = 0;
  logic [5:0]  err;
  logic [15:0] cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  halt_monitor #(.CREDIT_MAX(CMAX), .MIN_GAP(GAP), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .halt_req_i(req),
    .halt_ack_i(ack), .hash_run_i(hash), .cipher_busy_i(cipher),
    .approved_out_i(appr), .err_o(err), .unhalted_cnt_o(cnt)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    clr = 1; step(); clr = 0;
  endtask

  task automatic handshake();
    req = 1; step(); ack = 1; step(); req = 0; step(); ack = 0; step();
  endtask

  task automatic approve();
    appr = 1; step(); appr = 0;
  endtask

  task automatic pulse_hash();
    hash = 1; step(); hash = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags", {26'd0, err}, 0);
    chk("R1 count", {16'd0, cnt}, 0);
  endtask

  task automatic t_credit();
    handshake();
    approve();
    chk("R2 claim with credit", {31'd0, err[0]}, 0);
    approve();
    chk("R3 claim without credit", {31'd0, err[0]}, 1);
  endtask

  task automatic t_saturate();
    do_clear();
    for (int i = 0; i < CMAX + 2; i++) handshake();
    for (int i = 0; i < CMAX; i++) approve();
    chk("R4 claims up to cap", {31'd0, err[0]}, 0);
    approve();
    chk("R4 claim past cap", {31'd0, err[0]}, 1);
  endtask

  task automatic t_mutex();
    logic [15:0] c0;
    do_clear();
    c0 = cnt;
    pulse_hash();
    chk("R5 unhalted hash", {31'd0, err[1]}, 1);
    chk("R10 count step", {16'd0, cnt}, {16'd0, c0 + 16'd1});
    do_clear();
    c0 = cnt;
    req = 1; step(); ack = 1; step();
    pulse_hash();
    req = 0; step(); ack = 0; step();
    chk("R5 halted hash", {31'd0, err[1]}, 0);
    chk("R10 halted not counted", {16'd0, cnt}, {16'd0, c0});
  endtask

  task automatic t_cipher();
    do_clear();
    cipher = 1; step(); cipher = 0;
    chk("R6 busy outside halt", {31'd0, err[2]}, 0);
    req = 1; step(); ack = 1; step();
    cipher = 1; step(); cipher = 0;
    req = 0; step(); ack = 0; step();
    chk("R6 busy during halt", {31'd0, err[2]}, 1);
  endtask

  task automatic t_ack_fall();
    do_clear();
    req = 1; step(); ack = 1; step(); ack = 0; step();
    chk("R7 early ack drop", {31'd0, err[3]}, 1);
    chk("R8 not raised by drop", {31'd0, err[4]}, 0);
    req = 0; step();
  endtask

  task automatic t_ack_rise();
    do_clear();
    ack = 1; step();
    chk("R8 ack unasked", {31'd0, err[4]}, 1);
    chk("R7 not raised by rise", {31'd0, err[3]}, 0);
    ack = 0; step();
  endtask

  task automatic t_spacing();
    step(GAP + 5);
    do_clear();
    pulse_hash();
    step(GAP - 2);
    pulse_hash();
    chk("R9 gap one short", {31'd0, err[5]}, 1);
    step(GAP + 5);
    do_clear();
    pulse_hash();
    step(GAP - 1);
    pulse_hash();
    chk("R9 gap exact", {31'd0, err[5]}, 0);
  endtask

  task automatic t_clear();
    logic [15:0] c0;
    do_clear();
    cipher = 1; req = 1; ack = 1; step(); cipher = 0;
    chk("R11 flag set", {31'd0, err[2]}, 1);
    step(3);
    chk("R11 flag held", {31'd0, err[2]}, 1);
    c0 = cnt;
    clr = 1; step(); clr = 0;
    chk("R11 cleared", {26'd0, err}, 0);
    chk("R11 count kept", {16'd0, cnt}, {16'd0, c0});
    clr = 1; cipher = 1; step(); clr = 0; cipher = 0;
    chk("R11 same-cycle event kept", {31'd0, err[2]}, 1);
    req = 0; step(); ack = 0; step();
    // a finished handshake must survive a clear
    do_clear();
    approve();
    chk("R11 credit kept over clear", {31'd0, err[0]}, 0);
  endtask

  task automatic t_count_sat();
    hash = 1; step(65540); hash = 0;
    chk("R10 saturation", {16'd0, cnt}, 32'h0000ffff);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_credit();
    t_saturate();
    t_mutex();
    t_cipher();
    t_ack_fall();
    t_ack_rise();
    t_spacing();
    t_clear();
    t_count_sat();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule